// File: doc/BRIEF.md
# USB Root Port Status Controller

This block keeps the per-port status and control flags of a USB port that can act as host or device. It also runs the resume signalling sequence. Software reads one 8-bit status word and writes it with write-one-to-clear semantics for the change flags. The block watches the bus line state, an over-current fault input and port-disable events. It drives a resume request towards the transceiver and pulses a port-change-detect flag towards the controller's status register.

In host mode the block times the resume itself and clears the force-resume flag in hardware. It holds the K drive for `RESUME_CYCLES` clocks, waits `EOR_CYCLES` clocks of end-of-resume, and then returns to idle. Software never clears the flag itself.

In device mode, software may start resume only once the port has been suspended for `SUSP_MIN_CYCLES` clocks. The flag then stays set until the device reports that it is back in normal operation. Hardware also starts resume, in either mode, when it sees a J state followed directly by a K state while the port is suspended.

The resume sequencer is a four-state machine:

| State | Meaning |
|-------|---------|
| IDLE | No resume in progress. |
| DRIVE_K | Host mode: K is being driven. |
| EOR | Host mode: end-of-resume wait. |
| DEV_HOLD | Device mode: resume is held. |

Its transitions are:

- **start_host**: IDLE to DRIVE_K.
- **drive_done**: DRIVE_K to EOR, after `RESUME_CYCLES` clocks.
- **eor_done**: EOR to IDLE, after `EOR_CYCLES` clocks.
- **start_dev**: IDLE to DEV_HOLD.
- **dev_back**: DEV_HOLD to IDLE, on `dev_resume_done`.
- **power_off**: any state to IDLE, whenever host mode has port power at zero.

Top module: `usb_port_status_ctrl`

## Requirements
- R1: The status word places force-resume at bit 6, over-current change at bit 5, over-current active at bit 4 and port-enable change at bit 3. All other bits read zero. After reset the whole word reads zero.
- R2: In host mode with port power on, a write with bit 6 set starts resume. Force-resume and `resume_drive` are seen one cycle later.
- R3: `line_state` is encoded as SE0=2'b00, J=2'b01, K=2'b10. A J sampled on one clock and a K on the next, while `suspended` is high, sets force-resume and gives a one-cycle `pcd_pulse`. A J, SE0, K order does not trigger this, and neither does a J-to-K change while not suspended.
- R4: In host mode, `resume_drive` stays high for exactly `RESUME_CYCLES` cycles. Force-resume then stays set for `EOR_CYCLES` more cycles and clears by itself.
- R5: In host mode, a write with bit 6 clear during resume has no effect: the flag stays set and the drive duration is unchanged.
- R6: In host mode with port power at zero, force-resume and port-enable change read zero. A resume in progress is aborted, and resume start writes are ignored.
- R7: Over-current active reads the fault input delayed by one clock, and clears by itself when the fault goes away.
- R8: Over-current change is set when the fault becomes active. Writing one to bit 5 clears it. A set and a clear in the same cycle leave it set.
- R9: Port-enable change is set by a disconnect event or an end-of-frame disable event. Writing one to bit 3 clears it. A set in the same cycle as a clear wins.
- R10: In device mode, bits 5, 4 and 3 always read zero, whatever the fault and disable inputs do.
- R11: In device mode, a resume start write is ignored unless `suspended` has been high for at least `SUSP_MIN_CYCLES` clocks.
- R12: In device mode, force-resume and `resume_drive` stay high until `dev_resume_done` is seen. Force-resume reads zero on the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_mode | input | 1 | 1 = host, 0 = device |
| port_power | input | 1 | Port power control (host mode) |
| suspended | input | 1 | Port is in the suspend state |
| line_state | input | 2 | Bus line state: 00 SE0, 01 J, 10 K |
| oc_fault | input | 1 | Over-current fault indication |
| disc_evt | input | 1 | Port disabled by disconnect |
| eof_evt | input | 1 | Port disabled at end-of-frame check |
| dev_resume_done | input | 1 | Device back in normal operation |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read value |
| resume_drive | output | 1 | Request to drive resume K |
| pcd_pulse | output | 1 | One-cycle port-change-detect set |

## Verification
The assertions assume that the mode input and the event inputs are synchronous to `clk` and change only between edges. They also assume that `host_mode` is not switched while a resume is in progress, since a mode change mid-sequence has no defined outcome. The bench drives every input on the falling edge and changes mode only when force-resume reads zero. It waits out each resume sequence before starting the next scenario. It uses small cycle parameters so that full drive and end-of-resume windows are counted exactly.

// File: rtl/usbps_pkg.sv
package usbps_pkg;

    typedef enum logic [1:0] {
        LS_SE0 = 2'b00,
        LS_J   = 2'b01,
        LS_K   = 2'b10
    } line_e;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'b00,
        ST_DRIVE_K  = 2'b01,
        ST_EOR      = 2'b10,
        ST_DEV_HOLD = 2'b11
    } rsm_state_e;

    localparam int BIT_FR  = 6;
    localparam int BIT_OCC = 5;
    localparam int BIT_OCA = 4;
    localparam int BIT_PEC = 3;

endpackage

// File: rtl/usbps_line_mon.sv
module usbps_line_mon
    import usbps_pkg::*;
#(
    parameter int SUSP_MIN_CYCLES = 625_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       suspended,
    input  logic [1:0] line_state,
    output logic       jk_evt,
    output logic       susp_ok
);
    localparam int SW = $clog2(SUSP_MIN_CYCLES + 1);
    localparam logic [SW-1:0] SUSP_SAT = SW'(SUSP_MIN_CYCLES);

    logic [1:0]    ls_prev;
    logic [SW-1:0] susp_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ls_prev  <= LS_SE0;
            susp_cnt <= '0;
        end else begin
            ls_prev <= line_state;
            if (!suspended)
                susp_cnt <= '0;
            else if (susp_cnt != SUSP_SAT)
                susp_cnt <= susp_cnt + 1'b1;
        end
    end

    // J on the previous clock, K on this one, while suspended
    assign jk_evt  = suspended && (ls_prev == LS_J) && (line_state == LS_K);
    assign susp_ok = (susp_cnt == SUSP_SAT);

    a_r11_susp_timer_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !suspended |=> !susp_ok);

endmodule

// File: rtl/usbps_resume_fsm.sv
module usbps_resume_fsm
    import usbps_pkg::*;
#(
    parameter int RESUME_CYCLES = 2_500_000,
    parameter int EOR_CYCLES    = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic host_mode,
    input  logic port_power,
    input  logic sw_start,
    input  logic hw_start,
    input  logic wr_en,
    input  logic wr_fr,
    input  logic dev_resume_done,
    output logic fr,
    output logic resume_drive,
    output logic pcd_pulse
);
    localparam int MAXC = (RESUME_CYCLES > EOR_CYCLES) ? RESUME_CYCLES : EOR_CYCLES;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] RES_LAST = CW'(RESUME_CYCLES - 1);
    localparam logic [CW-1:0] EOR_LAST = CW'(EOR_CYCLES - 1);

    rsm_state_e st, st_nx;
    logic [CW-1:0] cnt;
    logic          host_off;
    logic          start;

    assign host_off = host_mode && !port_power;
    assign start    = sw_start || hw_start;

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:     if (start) st_nx = host_mode ? ST_DRIVE_K : ST_DEV_HOLD;
            ST_DRIVE_K:  if (cnt == RES_LAST) st_nx = ST_EOR;
            ST_EOR:      if (cnt == EOR_LAST) st_nx = ST_IDLE;
            ST_DEV_HOLD: if (dev_resume_done) st_nx = ST_IDLE;
        endcase
        if (host_off) st_nx = ST_IDLE;
    end

    // state register, counter and registered change pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            cnt       <= '0;
            pcd_pulse <= 1'b0;
        end else begin
            st        <= st_nx;
            cnt       <= (st_nx != st) ? '0 : cnt + 1'b1;
            pcd_pulse <= (st == ST_IDLE) && hw_start && !host_off;
        end
    end

    // outputs
    always_comb begin
        fr           = 1'b0;
        resume_drive = 1'b0;
        unique case (st)
            ST_IDLE:     ;
            ST_DRIVE_K:  begin fr = 1'b1; resume_drive = 1'b1; end
            ST_EOR:      fr = 1'b1;
            ST_DEV_HOLD: begin fr = 1'b1; resume_drive = 1'b1; end
        endcase
    end

    a_r5_write_zero_kept: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_DRIVE_K && cnt != RES_LAST && !host_off && wr_en && !wr_fr
        |=> st == ST_DRIVE_K);
    a_r6_power_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
        host_off |=> !fr);
    a_r3_pcd_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        pcd_pulse |-> fr && $past(st) == ST_IDLE);
    a_r12_dev_hold: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_DEV_HOLD && !dev_resume_done && !host_mode |=> fr && resume_drive);

endmodule

// File: rtl/usbps_status_bits.sv
module usbps_status_bits (
    input  logic clk,
    input  logic rst_n,
    input  logic host_mode,
    input  logic port_power,
    input  logic oc_fault,
    input  logic disc_evt,
    input  logic eof_evt,
    input  logic wr_en,
    input  logic wr_occ,
    input  logic wr_pec,
    output logic occ,
    output logic oca,
    output logic pec
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            occ <= 1'b0;
            oca <= 1'b0;
            pec <= 1'b0;
        end else if (!host_mode) begin
            occ <= 1'b0;
            oca <= 1'b0;
            pec <= 1'b0;
        end else begin
            oca <= oc_fault;
            if (oc_fault && !oca)
                occ <= 1'b1;
            else if (wr_en && wr_occ)
                occ <= 1'b0;
            if (!port_power)
                pec <= 1'b0;
            else if (disc_evt || eof_evt)
                pec <= 1'b1;
            else if (wr_en && wr_pec)
                pec <= 1'b0;
        end
    end

    a_r7_oca_follows: assert property (@(posedge clk) disable iff (!rst_n)
        host_mode |=> oca == $past(oc_fault));
    a_r8_occ_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        host_mode && oc_fault && !oca |=> occ);
    a_r9_pec_set: assert property (@(posedge clk) disable iff (!rst_n)
        host_mode && port_power && (disc_evt || eof_evt) |=> pec);
    a_r10_device_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !host_mode |=> !occ && !oca && !pec);

endmodule

// File: rtl/usb_port_status_ctrl.sv
module usb_port_status_ctrl
    import usbps_pkg::*;
#(
    parameter int RESUME_CYCLES   = 2_500_000,
    parameter int EOR_CYCLES      = 125,
    parameter int SUSP_MIN_CYCLES = 625_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_mode,
    input  logic       port_power,
    input  logic       suspended,
    input  logic [1:0] line_state,
    input  logic       oc_fault,
    input  logic       disc_evt,
    input  logic       eof_evt,
    input  logic       dev_resume_done,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic       resume_drive,
    output logic       pcd_pulse
);
    logic jk_evt, susp_ok;
    logic fr, occ, oca, pec;
    logic sw_start, hw_start, pwr_ok;
    logic wr_unused;

    assign wr_unused = ^{wr_data[7], wr_data[2:0]};
    assign pwr_ok    = !host_mode || port_power;

    usbps_line_mon #(.SUSP_MIN_CYCLES(SUSP_MIN_CYCLES)) u_line (
        .clk(clk), .rst_n(rst_n), .suspended(suspended),
        .line_state(line_state), .jk_evt(jk_evt), .susp_ok(susp_ok)
    );

    assign sw_start = wr_en && wr_data[BIT_FR] && (host_mode ? port_power : susp_ok);
    assign hw_start = jk_evt && pwr_ok;

    usbps_resume_fsm #(.RESUME_CYCLES(RESUME_CYCLES), .EOR_CYCLES(EOR_CYCLES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .host_mode(host_mode), .port_power(port_power),
        .sw_start(sw_start), .hw_start(hw_start), .wr_en(wr_en),
        .wr_fr(wr_data[BIT_FR]), .dev_resume_done(dev_resume_done),
        .fr(fr), .resume_drive(resume_drive), .pcd_pulse(pcd_pulse)
    );

    usbps_status_bits u_stat (
        .clk(clk), .rst_n(rst_n), .host_mode(host_mode), .port_power(port_power),
        .oc_fault(oc_fault), .disc_evt(disc_evt), .eof_evt(eof_evt),
        .wr_en(wr_en), .wr_occ(wr_data[BIT_OCC]), .wr_pec(wr_data[BIT_PEC]),
        .occ(occ), .oca(oca), .pec(pec)
    );

    always_comb begin
        rd_data          = '0;
        rd_data[BIT_FR]  = fr && pwr_ok;
        rd_data[BIT_OCC] = occ;
        rd_data[BIT_OCA] = oca;
        rd_data[BIT_PEC] = pec && pwr_ok;
    end

    a_r1_spare_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[7] == 1'b0 && rd_data[2:0] == 3'b000);
    a_r4_drive_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
        resume_drive && pwr_ok |-> rd_data[BIT_FR]);

endmodule

// File: tb/tb_usb_port_status_ctrl.sv
`timescale 1ns/1ps
module tb_usb_port_status_ctrl;
    localparam int RES  = 10;
    localparam int EOR  = 3;
    localparam int SUSP = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_mode = 1'b1, port_power = 1'b1, suspended = 1'b0;
    logic [1:0] line_state = 2'b01;
    logic oc_fault = 1'b0, disc_evt = 1'b0, eof_evt = 1'b0, dev_resume_done = 1'b0;
    logic wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic resume_drive, pcd_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    usb_port_status_ctrl #(.RESUME_CYCLES(RES), .EOR_CYCLES(EOR), .SUSP_MIN_CYCLES(SUSP)) dut (
        .clk(clk), .rst_n(rst_n), .host_mode(host_mode), .port_power(port_power),
        .suspended(suspended), .line_state(line_state), .oc_fault(oc_fault),
        .disc_evt(disc_evt), .eof_evt(eof_evt), .dev_resume_done(dev_resume_done),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .resume_drive(resume_drive), .pcd_pulse(pcd_pulse)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 8'h00;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 100 && rd_data[6]; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 reset word", rd_data, 8'h00);
        chk("R1 reset drive", resume_drive, 0);
        chk("R1 reset pcd", pcd_pulse, 0);
    endtask

    task automatic t_host_resume();
        int n;
        wr(8'h40);
        chk("R2 fr set", rd_data[6], 1);
        chk("R1 only bit6", rd_data, 8'h40);
        n = 0;
        while (resume_drive && n < 100) begin n++; @(negedge clk); end
        chk("R4 drive length", n, RES);
        n = 0;
        while (rd_data[6] && n < 100) begin n++; @(negedge clk); end
        chk("R4 eor length", n, EOR);
        chk("R4 cleared", rd_data[6], 0);
    endtask

    task automatic t_write_zero();
        int n;
        wr(8'h40);
        wr(8'h00);
        chk("R5 fr kept", rd_data[6], 1);
        n = 2;
        while (resume_drive && n < 100) begin n++; @(negedge clk); end
        chk("R5 drive length unchanged", n, RES + 1);
        wait_idle();
    endtask

    task automatic t_jk();
        suspended = 1'b1; line_state = 2'b01; cyc(1);
        line_state = 2'b10; cyc(1);
        chk("R3 jk fr", rd_data[6], 1);
        chk("R3 pcd pulse", pcd_pulse, 1);
        cyc(1);
        chk("R3 pcd one cycle", pcd_pulse, 0);
        line_state = 2'b01;
        wait_idle();
        cyc(1);
        line_state = 2'b00; cyc(1);
        line_state = 2'b10; cyc(1);
        chk("R3 J-SE0-K ignored", rd_data[6], 0);
        chk("R3 J-SE0-K no pcd", pcd_pulse, 0);
        suspended = 1'b0; line_state = 2'b01; cyc(1);
        line_state = 2'b10; cyc(1);
        chk("R3 not suspended ignored", rd_data[6], 0);
        line_state = 2'b01; cyc(1);
    endtask

    task automatic t_power();
        wr(8'h40);
        disc_evt = 1'b1; cyc(1); disc_evt = 1'b0;
        chk("R9 pec before power off", rd_data[3], 1);
        port_power = 1'b0; cyc(1);
        chk("R6 fr zero no power", rd_data[6], 0);
        chk("R6 pec zero no power", rd_data[3], 0);
        wr(8'h40);
        chk("R6 start ignored", rd_data[6], 0);
        port_power = 1'b1; cyc(1);
        chk("R6 still idle after power", rd_data[6], 0);
        chk("R6 drive off", resume_drive, 0);
    endtask

    task automatic t_oc();
        oc_fault = 1'b1; cyc(1);
        chk("R7 oca set", rd_data[4], 1);
        chk("R8 occ set", rd_data[5], 1);
        wr(8'h20);
        chk("R8 occ cleared", rd_data[5], 0);
        chk("R7 oca held", rd_data[4], 1);
        oc_fault = 1'b0; cyc(1);
        chk("R7 oca self clear", rd_data[4], 0);
        oc_fault = 1'b1; wr(8'h20);
        chk("R8 set wins", rd_data[5], 1);
        oc_fault = 1'b0; wr(8'h20);
        chk("R8 final clear", rd_data[5:4], 0);
    endtask

    task automatic t_pec();
        eof_evt = 1'b1; cyc(1); eof_evt = 1'b0;
        chk("R9 pec by eof", rd_data[3], 1);
        wr(8'h08);
        chk("R9 pec cleared", rd_data[3], 0);
        disc_evt = 1'b1; wr(8'h08); disc_evt = 1'b0;
        chk("R9 set wins", rd_data[3], 1);
        wr(8'h08);
        chk("R9 final clear", rd_data[3], 0);
    endtask

    task automatic t_device();
        host_mode = 1'b0; oc_fault = 1'b1; disc_evt = 1'b1; cyc(2);
        chk("R10 device zero bits", rd_data[5:3], 0);
        oc_fault = 1'b0; disc_evt = 1'b0;
        suspended = 1'b1; cyc(1);
        wr(8'h40);
        chk("R11 early start ignored", rd_data[6], 0);
        cyc(SUSP + 2);
        wr(8'h40);
        chk("R11 start after suspend", rd_data[6], 1);
        cyc(20);
        chk("R12 fr held", rd_data[6], 1);
        chk("R12 drive held", resume_drive, 1);
        dev_resume_done = 1'b1; cyc(1); dev_resume_done = 1'b0;
        chk("R12 cleared", rd_data[6], 0);
        suspended = 1'b0;
    endtask

    initial begin
        cyc(2);
        t_reset();
        rst_n = 1'b1;
        cyc(2);
        t_host_resume();
        t_write_zero();
        t_jk();
        t_power();
        t_oc();
        t_pec();
        t_device();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule